// File: doc/BRIEF.md
# Half-Bias Multiplexed Segment LCD Waveform Generator

This block produces the drive pattern for a multiplexed segment LCD panel with two to four common electrodes and up to sixteen segment electrodes, using one-half bias. Each common line leaves the block as a two-bit level code: high, mid or low. An external pad stage turns that code into a voltage. Each segment line is a plain logic level. A timer prescaler outside the block supplies a single-cycle tick, and every time in this block is counted in those ticks.

A refresh frame holds two active slots per common, each `alpha` ticks long. In the first slot the selected common is high, and in the second it is low. Every other common sits at the mid level. A segment whose pixel is lit drives the level opposite to the selected common, so the pixel sees the full supply. An unlit segment follows the common, so its pixel sees nothing. Whatever is left of the programmed frame length after the slots becomes dead time. During dead time every common and every segment is high, so no pixel sees any voltage.

Contrast is set by trading slot width against dead time while the refresh period stays the same. The common count, slot width, frame length and pixel bitmap are sampled only when a frame begins. A one-cycle pulse marks that moment.

Top module: `lcd_halfbias_drv`

## Requirements
- R1: Common level codes are high = 2'b10, mid = 2'b01 and low = 2'b00. Common `k` occupies bits [2k+1:2k] of `com_lvl_o`. Active slots run in the order common 0 high, common 0 low, common 1 high, common 1 low, and so on. Each slot lasts `alpha` ticks. Every common other than the selected one is at mid during a slot.
- R2: The bit for segment `s` on common `c` is `pix_i[c*NSEG+s]`. During a slot, a segment whose bit is 1 drives the opposite of the selected common's level. A segment whose bit is 0 drives the same level as the selected common.
- R3: The common count is taken from `num_com_i`. A value below 2 is treated as 2 and a value above 4 as 4. A frame contains exactly 2·n active slots.
- R4: After the last slot, dead time lasts (frame length − 2·n·alpha) ticks. During dead time every common code is high and every segment is 1.
- R5: When 2·n·alpha is below the frame length, the frame lasts exactly `frame_len_i` ticks whatever the value of alpha.
- R6: An `alpha_i` below `ALPHA_MIN` (default 4 ticks) is raised to `ALPHA_MIN`.
- R7: When 2·n·alpha is equal to or above the frame length, no dead tick is inserted. The next frame follows the last slot directly.
- R8: Common count, alpha, frame length and pixel bitmap are sampled only on the tick that starts a frame. Changes during a frame do not alter that frame.
- R9: `frame_start_o` is high for exactly one clock, on the clock after the tick that starts a frame. The outputs then show slot 0.
- R10: After reset all outputs show the dead pattern and `frame_start_o` is low. The first tick starts a frame. Outputs change only on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle time-base strobe from the prescaler |
| num_com_i | input | 3 | Requested common count (2..4) |
| alpha_i | input | 16 | Active slot width in ticks |
| frame_len_i | input | 16 | Refresh frame length in ticks |
| pix_i | input | 64 | Pixel bitmap, segment-major within each common |
| com_lvl_o | output | 8 | Two-bit level code per common line |
| seg_o | output | 16 | Segment line levels |
| frame_start_o | output | 1 | One-clock pulse at the start of each frame |

## Verification
The hardest situation to reach from the ports is a settings change that arrives in the middle of a frame. If a design applied it early, the damage would only show as a slot of the wrong width, or a wrong pixel row, several ticks later. The stimulus therefore overwrites every setting partway through chosen frames. It restores the intended values before the frame boundary, and the scoreboard checks each tick of the untouched frame against its prediction. The second corner is the frame with no dead time. The bench reaches it by programming 2·n·alpha exactly equal to, and above, the frame length, and then checking that the next frame's first slot follows immediately.

// File: rtl/lcd_hb_pkg.sv
package lcd_hb_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;
endpackage

// File: rtl/lcd_hb_cfg.sv
module lcd_hb_cfg #(
  parameter int NSEG      = 16,
  parameter int MAXCOM    = 4,
  parameter int CW        = 16,
  parameter int ALPHA_MIN = 4,
  localparam int NCW      = $clog2(MAXCOM + 1),
  localparam int ACTW     = CW + 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [NCW-1:0]         num_com_i,
  input  logic [CW-1:0]          alpha_i,
  input  logic [CW-1:0]          frame_len_i,
  input  logic [NSEG*MAXCOM-1:0] pix_i,
  output logic [NCW-1:0]         ncom_q,
  output logic [CW-1:0]          alpha_q,
  output logic [CW-1:0]          dead_q,
  output logic [NSEG*MAXCOM-1:0] pix_q
);
  localparam logic [NCW-1:0] NC_MIN = NCW'(2);
  localparam logic [NCW-1:0] NC_MAX = NCW'(MAXCOM);

  logic [NCW-1:0]  ncom_c;
  logic [CW-1:0]   alpha_c;
  logic [ACTW-1:0] act_c;
  logic [ACTW-1:0] len_c;
  logic [CW-1:0]   dead_c;

  always_comb begin
    if (num_com_i < NC_MIN)      ncom_c = NC_MIN;
    else if (num_com_i > NC_MAX) ncom_c = NC_MAX;
    else                         ncom_c = num_com_i;
    alpha_c = (alpha_i < CW'(ALPHA_MIN)) ? CW'(ALPHA_MIN) : alpha_i;
    act_c   = (ACTW'(alpha_c) * ACTW'(ncom_c)) << 1;
    len_c   = ACTW'(frame_len_i);
    dead_c  = (len_c > act_c) ? CW'(len_c - act_c) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncom_q  <= NC_MIN;
      alpha_q <= CW'(ALPHA_MIN);
      dead_q  <= '0;
      pix_q   <= '0;
    end else if (load_i) begin
      ncom_q  <= ncom_c;
      alpha_q <= alpha_c;
      dead_q  <= dead_c;
      pix_q   <= pix_i;
    end
  end

  // R6
  alpha_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alpha_q >= CW'(ALPHA_MIN));
endmodule

// File: rtl/lcd_hb_seq.sv
module lcd_hb_seq #(
  parameter int MAXCOM = 4,
  parameter int CW     = 16,
  localparam int NCW   = $clog2(MAXCOM + 1),
  localparam int SW    = $clog2(2 * MAXCOM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic [NCW-1:0] ncom_q,
  input  logic [CW-1:0]  alpha_q,
  input  logic [CW-1:0]  dead_q,
  output logic [SW-1:0]  slot_o,
  output logic           dead_ph_o,
  output logic           frame_go_o,
  output logic           frame_start_o
);
  logic          pend;
  logic [CW-1:0] cnt;
  logic [SW:0]   nslot;
  logic          last_slot, act_end, dead_end;

  always_comb begin
    nslot      = (SW+1)'({ncom_q, 1'b0});
    last_slot  = ({1'b0, slot_o} == nslot - 1'b1);
    act_end    = !dead_ph_o && (cnt == alpha_q - 1'b1);
    dead_end   = dead_ph_o && (cnt == dead_q - 1'b1);
    frame_go_o = tick_i && (pend || dead_end ||
                 (act_end && last_slot && (dead_q == '0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend          <= 1'b1;
      dead_ph_o     <= 1'b1;
      slot_o        <= '0;
      cnt           <= '0;
      frame_start_o <= 1'b0;
    end else begin
      frame_start_o <= frame_go_o;
      if (frame_go_o) begin
        pend      <= 1'b0;
        dead_ph_o <= 1'b0;
        slot_o    <= '0;
        cnt       <= '0;
      end else if (tick_i) begin
        if (act_end) begin
          cnt <= '0;
          if (last_slot) dead_ph_o <= 1'b1;
          else           slot_o    <= slot_o + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(slot_o) && $stable(cnt) && $stable(dead_ph_o)));
  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dead_ph_o |-> ({1'b0, slot_o} < nslot));
  // R1
  slot_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dead_ph_o |-> (cnt < alpha_q));
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);
endmodule

// File: rtl/lcd_hb_out.sv
module lcd_hb_out #(
  parameter int NSEG   = 16,
  parameter int MAXCOM = 4,
  localparam int SW    = $clog2(2 * MAXCOM)
) (
  input  logic [SW-1:0]          slot_i,
  input  logic                   dead_ph_i,
  input  logic [NSEG*MAXCOM-1:0] pix_q,
  output logic [2*MAXCOM-1:0]    com_lvl_o,
  output logic [NSEG-1:0]        seg_o
);
  import lcd_hb_pkg::*;

  logic [SW-2:0]   cur;
  logic            pol_hi;
  logic [NSEG-1:0] row;

  assign cur    = slot_i[SW-1:1];
  assign pol_hi = ~slot_i[0];

  always_comb begin
    row = '0;
    for (int k = 0; k < MAXCOM; k++)
      if (cur == (SW-1)'(k)) row = pix_q[k*NSEG +: NSEG];
  end

  for (genvar j = 0; j < MAXCOM; j++) begin : g_com
    always_comb begin
      if (dead_ph_i)                com_lvl_o[2*j +: 2] = LVL_HIGH;
      else if (cur == (SW-1)'(j))   com_lvl_o[2*j +: 2] = pol_hi ? LVL_HIGH : LVL_LOW;
      else                          com_lvl_o[2*j +: 2] = LVL_MID;
    end
  end

  assign seg_o = dead_ph_i ? '1 : (pol_hi ? ~row : row);
endmodule

// File: rtl/lcd_halfbias_drv.sv
module lcd_halfbias_drv #(
  parameter int NSEG      = 16,
  parameter int MAXCOM    = 4,
  parameter int CW        = 16,
  parameter int ALPHA_MIN = 4,
  localparam int NCW      = $clog2(MAXCOM + 1),
  localparam int SW       = $clog2(2 * MAXCOM)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic [NCW-1:0]         num_com_i,
  input  logic [CW-1:0]          alpha_i,
  input  logic [CW-1:0]          frame_len_i,
  input  logic [NSEG*MAXCOM-1:0] pix_i,
  output logic [2*MAXCOM-1:0]    com_lvl_o,
  output logic [NSEG-1:0]        seg_o,
  output logic                   frame_start_o
);
  import lcd_hb_pkg::*;

  logic [NCW-1:0]         ncom_q;
  logic [CW-1:0]          alpha_q, dead_q;
  logic [NSEG*MAXCOM-1:0] pix_q;
  logic [SW-1:0]          slot;
  logic                   dead_ph, frame_go;

  lcd_hb_cfg #(.NSEG(NSEG), .MAXCOM(MAXCOM), .CW(CW), .ALPHA_MIN(ALPHA_MIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(frame_go),
    .num_com_i(num_com_i), .alpha_i(alpha_i), .frame_len_i(frame_len_i), .pix_i(pix_i),
    .ncom_q(ncom_q), .alpha_q(alpha_q), .dead_q(dead_q), .pix_q(pix_q)
  );

  lcd_hb_seq #(.MAXCOM(MAXCOM), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .ncom_q(ncom_q), .alpha_q(alpha_q), .dead_q(dead_q),
    .slot_o(slot), .dead_ph_o(dead_ph), .frame_go_o(frame_go),
    .frame_start_o(frame_start_o)
  );

  lcd_hb_out #(.NSEG(NSEG), .MAXCOM(MAXCOM)) u_out (
    .slot_i(slot), .dead_ph_i(dead_ph), .pix_q(pix_q),
    .com_lvl_o(com_lvl_o), .seg_o(seg_o)
  );

  logic [MAXCOM-1:0] not_mid;
  always_comb
    for (int j = 0; j < MAXCOM; j++)
      not_mid[j] = (com_lvl_o[2*j +: 2] != LVL_MID);

  // R1
  one_common_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dead_ph |-> ($countones(not_mid) == 1));
  // R9
  start_shows_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (com_lvl_o[1:0] == LVL_HIGH && !dead_ph));
endmodule

// File: tb/lcd_halfbias_drv_tb.sv
`timescale 1ns/1ps
module lcd_halfbias_drv_tb;
  typedef struct packed {
    logic [7:0]  com;
    logic [15:0] seg;
    logic        fs;
    logic        dead;
  } item_t;

  logic        clk = 0, rst_n = 0, tick = 0;
  logic [2:0]  num_com = 3'd2;
  logic [15:0] alpha = 16'd4, flen = 16'd40;
  logic [63:0] pix = '0;
  logic [7:0]  com_lvl;
  logic [15:0] seg;
  logic        fstart;

  int    checks = 0, fails = 0;
  bit    done = 0, second = 0;
  string ctx = "R10";
  item_t expq[$];
  item_t last_it;
  event  smp_ev;

  always #4 clk = ~clk;

  lcd_halfbias_drv u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .num_com_i(num_com),
    .alpha_i(alpha), .frame_len_i(flen), .pix_i(pix),
    .com_lvl_o(com_lvl), .seg_o(seg), .frame_start_o(fstart)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): actual=%h expected=%h at %0t", req, ctx, act, exp, $time);
    end
  endtask

  function automatic item_t exp_at(int n, int a, int act, int i, logic [63:0] p);
    item_t it;
    int slot, c;
    bit hi;
    logic [15:0] row;
    it.fs = (i == 0);
    if (i >= act) begin
      it.dead = 1; it.com = 8'hAA; it.seg = 16'hFFFF;
    end else begin
      slot = i / a; c = slot / 2; hi = (slot % 2) == 0;
      it.dead = 0;
      for (int j = 0; j < 4; j++)
        it.com[2*j +: 2] = (j == c) ? (hi ? 2'b10 : 2'b00) : 2'b01;
      row = p[c*16 +: 16];
      it.seg = hi ? ~row : row;
    end
    return it;
  endfunction

  // monitor: pops one expectation per tick, re-checks it one clock later
  initial forever begin
    @(smp_ev);
    if (!second) begin
      if (expq.size() == 0) begin
        chk("R5", 32'd1, 32'd0);
      end else begin
        last_it = expq.pop_front();
        chk(last_it.dead ? "R4" : "R1", {24'd0, com_lvl}, {24'd0, last_it.com});
        chk(last_it.dead ? "R4" : "R2", {16'd0, seg}, {16'd0, last_it.seg});
        chk("R9", {31'd0, fstart}, {31'd0, last_it.fs});
      end
    end else begin
      chk("R10", {8'd0, com_lvl, seg}, {8'd0, last_it.com, last_it.seg});
      chk("R9", {31'd0, fstart}, 32'd0);
    end
  end

  task automatic do_tick();
    tick = 1;
    @(negedge clk); tick = 0;
    second = 0; -> smp_ev;
    @(negedge clk);
    second = 1; -> smp_ev;
  endtask

  // driver: programs a frame, pushes its expected ticks, then runs it
  task automatic run_frame(input string tag, input int n_in, input int a_in,
                           input int len_in, input logic [63:0] p, input int chg_at);
    int n, a, act, total;
    ctx = tag;
    num_com = 3'(n_in); alpha = 16'(a_in); flen = 16'(len_in); pix = p;
    n = (n_in < 2) ? 2 : (n_in > 4) ? 4 : n_in;
    a = (a_in < 4) ? 4 : a_in;
    act = 2 * n * a;
    total = (len_in > act) ? len_in : act;
    for (int i = 0; i < total; i++) expq.push_back(exp_at(n, a, act, i, p));
    for (int i = 0; i < total; i++) begin
      if (i == chg_at) begin
        num_com = 3'(6 - n); alpha = 16'(a + 3); flen = 16'(len_in + 7); pix = ~p;
      end
      do_tick();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset pattern: all commons high, all segments high, no start pulse
    chk("R10", {24'd0, com_lvl}, 32'h0000_00AA);
    chk("R10", {16'd0, seg}, 32'h0000_FFFF);
    chk("R10", {31'd0, fstart}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R10", {24'd0, com_lvl}, 32'h0000_00AA);

    run_frame("R1", 3, 5, 40, 64'h0000_A5A5_0F0F_1234, -1);
    run_frame("R5", 2, 6, 40, 64'h0000_0000_FFFF_8001, -1);
    run_frame("R5", 4, 4, 40, 64'hDEAD_BEEF_0123_4567, -1);
    run_frame("R6", 2, 1, 30, 64'h0000_0000_00FF_FF00, -1);
    run_frame("R7", 4, 5, 40, 64'h1111_2222_4444_8888, -1);
    run_frame("R7", 3, 8, 20, 64'h0000_C3C3_3C3C_AAAA, -1);
    run_frame("R3", 1, 4, 24, 64'h0000_0000_5555_AAAA, -1);
    run_frame("R3", 7, 4, 40, 64'hF00F_0FF0_00FF_FF00, -1);
    run_frame("R8", 3, 4, 36, 64'h0000_1357_9BDF_2468, 7);
    run_frame("R8", 2, 5, 30, 64'h0000_0000_ABCD_EF01, 12);
    run_frame("R4", 2, 4, 24, 64'h0000_0000_0000_0000, -1);

    ctx = "R5";
    chk("R5", 32'(expq.size()), 32'd0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule